// File: doc/BRIEF.md
# Memory Fill Chunk Sequencer

This block takes one request to fill a region of memory with a repeated 32-bit word. It turns that request into a series of two-dimensional copy-engine descriptors. No single descriptor may exceed the engine's largest line width or line count, which are both 32768 words. A request gives a 64-bit destination address, a 64-bit byte count and the fill word, and a one-cycle start pulse launches it.

Each descriptor carries the following:
- the destination address;
- a line width in 32-bit words;
- a line count;
- a flag that marks a multi-line launch;
- a fixed line pitch of 32768 × 4 bytes;
- the latched fill word.

Descriptors leave through a valid/ready handshake. Each chunk takes its shape from the bytes still to be written. It is a full 32768 × 32768 square when enough bytes remain. Otherwise it is a block of full-width rows when at least one row remains. Otherwise it is a single short row. After each accepted chunk the address moves forward and the remaining count drops by the chunk's byte size. The sequence ends once fewer than 4 bytes remain, and those trailing bytes are never covered. A done pulse follows the last chunk.

Top module: `fill_split`

## Requirements
- R1: After reset, chunk_valid_o, done_o and busy_o are all 0.
- R2: While the remaining count is at least 2^32 bytes (32768 × 32768 × 4), the offered chunk has width 32768 and height 32768, with chunk_multi_o = 1.
- R3: While the remaining count is below 2^32 but at least 131072 bytes (32768 × 4), the offered chunk has width 32768 and height equal to the remaining count divided by 131072, rounded down.
- R4: While the remaining count is below 131072 and at least 4, the offered chunk has width equal to the remaining count divided by 4, rounded down, and height 1.
- R5: On each accepted chunk, the address advances and the remaining count drops by width × height × 4 bytes. The first chunk's address is the requested address. Chunks are offered until fewer than 4 bytes remain, so the accepted chunks cover exactly the requested size rounded down to a multiple of 4.
- R6: chunk_multi_o is 1 exactly when the offered height is greater than 1.
- R7: chunk_pitch_o is always 131072. chunk_fill_o equals the fill word captured with the start pulse, and changes to fill_i after the start pulse do not affect it.
- R8: While chunk_valid_o is 1 and chunk_ready_i is 0, chunk_valid_o stays 1 and every chunk field stays unchanged.
- R9: done_o is 1 for exactly one cycle, namely the cycle after the final chunk is accepted. In that cycle chunk_valid_o is 0, and busy_o returns to 0 the cycle after.
- R10: A request with a size below 4 bytes offers no chunk, and done_o is 1 in the cycle after the start pulse.
- R11: A start pulse while busy_o is 1 is ignored: the chunk sequence of the running request is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request launch, taken only when idle |
| dst_addr_i | input | 64 | Destination byte address of the fill |
| size_i | input | 64 | Fill length in bytes |
| fill_i | input | 32 | Word written repeatedly |
| busy_o | output | 1 | A request is in progress |
| chunk_valid_o | output | 1 | A chunk descriptor is offered |
| chunk_ready_i | input | 1 | Consumer accepts the offered chunk |
| chunk_addr_o | output | 64 | Chunk destination address |
| chunk_width_o | output | 16 | Line width in 32-bit words |
| chunk_height_o | output | 16 | Line count |
| chunk_multi_o | output | 1 | Multi-line launch flag |
| chunk_pitch_o | output | 32 | Line pitch in bytes (constant) |
| chunk_fill_o | output | 32 | Fill word for this request |
| done_o | output | 1 | One-cycle pulse after the last chunk |

## Verification
The hardest situations to reach are the shape boundaries:
- a remaining count of exactly 2^32, 2^32 − 4, 131072 and 131071;
- a request whose sequence moves through all three shapes in turn.

Random sizes almost never land on these values, so directed requests supply them. They include sizes of the form 2^32 + k × 131072 + small tails. Random back-pressure holds chunks stalled. During one stall a second start pulse with different arguments arrives, which shows that the running sequence and its hold behaviour are untouched.

// File: rtl/fill_split_pkg.sv
package fill_split_pkg;

    localparam int FS_ADDR_W    = 64;
    localparam int FS_SIZE_W    = 64;
    localparam int FS_WORD_W    = 32;
    localparam int FS_PITCH_W   = 32;
    localparam int FS_DIM_LOG2  = 15;
    localparam int FS_BYTE_LOG2 = 2;

    localparam int FS_DIM_W     = FS_DIM_LOG2 + 1;
    localparam int FS_ROW_SHIFT = FS_DIM_LOG2 + FS_BYTE_LOG2;
    localparam int FS_SQ_SHIFT  = 2 * FS_DIM_LOG2 + FS_BYTE_LOG2;

    localparam logic [FS_SIZE_W-1:0]  FS_WORD_BYTES = FS_SIZE_W'(1) << FS_BYTE_LOG2;
    localparam logic [FS_SIZE_W-1:0]  FS_ROW_BYTES  = FS_SIZE_W'(1) << FS_ROW_SHIFT;
    localparam logic [FS_SIZE_W-1:0]  FS_SQ_BYTES   = FS_SIZE_W'(1) << FS_SQ_SHIFT;
    localparam logic [FS_DIM_W-1:0]   FS_DIM_MAX    = FS_DIM_W'(1) << FS_DIM_LOG2;
    localparam logic [FS_PITCH_W-1:0] FS_PITCH      = FS_PITCH_W'(1) << FS_ROW_SHIFT;

    typedef enum logic [1:0] {
        FS_IDLE   = 2'd0,
        FS_EMIT   = 2'd1,
        FS_FINISH = 2'd2
    } fs_state_e;

    typedef struct packed {
        logic [FS_DIM_W-1:0]  width;
        logic [FS_DIM_W-1:0]  height;
        logic                 multi;
        logic [FS_SIZE_W-1:0] bytes;
    } fs_chunk_t;

    function automatic logic fs_has_word(input logic [FS_SIZE_W-1:0] n);
        return n >= FS_WORD_BYTES;
    endfunction

endpackage

// File: rtl/fill_chunk_calc.sv
module fill_chunk_calc
    import fill_split_pkg::*;
(
    input  logic [FS_SIZE_W-1:0] remain_i,
    output fs_chunk_t            chunk_o,
    output logic                 last_o
);

    logic [FS_SIZE_W-1:0] left;

    always_comb begin
        chunk_o = '0;
        if (remain_i >= FS_SQ_BYTES) begin
            chunk_o.width  = FS_DIM_MAX;
            chunk_o.height = FS_DIM_MAX;
            chunk_o.bytes  = FS_SQ_BYTES;
        end else if (remain_i >= FS_ROW_BYTES) begin
            chunk_o.width  = FS_DIM_MAX;
            chunk_o.height = FS_DIM_W'(remain_i >> FS_ROW_SHIFT);
            chunk_o.bytes  = FS_SIZE_W'(chunk_o.height) << FS_ROW_SHIFT;
        end else begin
            chunk_o.width  = FS_DIM_W'(remain_i >> FS_BYTE_LOG2);
            chunk_o.height = FS_DIM_W'(1);
            chunk_o.bytes  = FS_SIZE_W'(chunk_o.width) << FS_BYTE_LOG2;
        end
        chunk_o.multi = chunk_o.height > FS_DIM_W'(1);
    end

    assign left   = remain_i - chunk_o.bytes;
    assign last_o = !fs_has_word(left);

endmodule

// File: rtl/fill_cursor.sv
module fill_cursor
    import fill_split_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load_i,
    input  logic [FS_ADDR_W-1:0] ld_addr_i,
    input  logic [FS_SIZE_W-1:0] ld_size_i,
    input  logic [FS_WORD_W-1:0] ld_fill_i,
    input  logic                 step_i,
    input  logic [FS_SIZE_W-1:0] step_bytes_i,
    output logic [FS_ADDR_W-1:0] addr_o,
    output logic [FS_SIZE_W-1:0] remain_o,
    output logic [FS_WORD_W-1:0] fill_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_o   <= '0;
            remain_o <= '0;
            fill_o   <= '0;
        end else if (load_i) begin
            addr_o   <= ld_addr_i;
            remain_o <= ld_size_i;
            fill_o   <= ld_fill_i;
        end else if (step_i) begin
            addr_o   <= addr_o + FS_ADDR_W'(step_bytes_i);
            remain_o <= remain_o - step_bytes_i;
        end
    end

endmodule

// File: rtl/fill_split_ctrl.sv
module fill_split_ctrl
    import fill_split_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start_i,
    input  logic      size_ok_i,
    input  logic      accept_i,
    input  logic      last_i,
    output logic      load_o,
    output fs_state_e state_o
);

    fs_state_e state_q, state_d;

    assign load_o = start_i && (state_q == FS_IDLE);

    always_comb begin
        state_d = state_q;
        case (state_q)
            FS_IDLE:   if (load_o) state_d = size_ok_i ? FS_EMIT : FS_FINISH;
            FS_EMIT:   if (accept_i && last_i) state_d = FS_FINISH;
            FS_FINISH: state_d = FS_IDLE;
            default:   state_d = FS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= FS_IDLE;
        else     state_q <= state_d;
    end

    assign state_o = state_q;

endmodule

// File: rtl/fill_split.sv
module fill_split
    import fill_split_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start_i,
    input  logic [FS_ADDR_W-1:0]  dst_addr_i,
    input  logic [FS_SIZE_W-1:0]  size_i,
    input  logic [FS_WORD_W-1:0]  fill_i,
    output logic                  busy_o,
    output logic                  chunk_valid_o,
    input  logic                  chunk_ready_i,
    output logic [FS_ADDR_W-1:0]  chunk_addr_o,
    output logic [FS_DIM_W-1:0]   chunk_width_o,
    output logic [FS_DIM_W-1:0]   chunk_height_o,
    output logic                  chunk_multi_o,
    output logic [FS_PITCH_W-1:0] chunk_pitch_o,
    output logic [FS_WORD_W-1:0]  chunk_fill_o,
    output logic                  done_o
);

    fs_state_e            state;
    fs_chunk_t            chunk;
    logic                 load, accept, last;
    logic [FS_SIZE_W-1:0] remain;

    fill_split_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start_i),
        .size_ok_i (fs_has_word(size_i)),
        .accept_i  (accept),
        .last_i    (last),
        .load_o    (load),
        .state_o   (state)
    );

    fill_cursor u_cursor (
        .clk          (clk),
        .rst          (rst),
        .load_i       (load),
        .ld_addr_i    (dst_addr_i),
        .ld_size_i    (size_i),
        .ld_fill_i    (fill_i),
        .step_i       (accept),
        .step_bytes_i (chunk.bytes),
        .addr_o       (chunk_addr_o),
        .remain_o     (remain),
        .fill_o       (chunk_fill_o)
    );

    fill_chunk_calc u_calc (
        .remain_i (remain),
        .chunk_o  (chunk),
        .last_o   (last)
    );

    assign chunk_valid_o  = (state == FS_EMIT);
    assign done_o         = (state == FS_FINISH);
    assign busy_o         = (state != FS_IDLE);
    assign accept         = chunk_valid_o && chunk_ready_i;
    assign chunk_width_o  = chunk.width;
    assign chunk_height_o = chunk.height;
    assign chunk_multi_o  = chunk.multi;
    assign chunk_pitch_o  = FS_PITCH;

    AST_DIM_RANGE: assert property (@(posedge clk) disable iff (rst)
        chunk_valid_o |-> (chunk_width_o != '0) && (chunk_height_o != '0)
                       && (chunk_width_o <= FS_DIM_MAX) && (chunk_height_o <= FS_DIM_MAX)); // R2

    AST_ROWS_FULL: assert property (@(posedge clk) disable iff (rst)
        (chunk_valid_o && chunk_height_o > FS_DIM_W'(1)) |-> chunk_width_o == FS_DIM_MAX); // R3

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
        (accept && !last) |=> chunk_valid_o && (chunk_addr_o == $past(chunk_addr_o)
            + FS_ADDR_W'($past(chunk_width_o)) * FS_ADDR_W'($past(chunk_height_o)) * FS_ADDR_W'(4))); // R5

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (chunk_valid_o && !chunk_ready_i) |=> chunk_valid_o && $stable(chunk_addr_o)
            && $stable(chunk_width_o) && $stable(chunk_height_o) && $stable(chunk_fill_o)); // R8

    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
        (accept && last) |=> done_o && !chunk_valid_o); // R9

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o && !busy_o); // R9

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (start_i && chunk_valid_o && !chunk_ready_i) |=> $stable(chunk_addr_o) && $stable(chunk_fill_o)); // R11

endmodule

// File: tb/fill_split_bench.sv
module fill_split_bench;

    localparam longint unsigned SQ  = 64'h1_0000_0000;
    localparam longint unsigned ROW = 64'd131072;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [63:0] dst_addr_i = '0;
    logic [63:0] size_i = '0;
    logic [31:0] fill_i = '0;
    logic        chunk_ready_i = 1'b0;
    logic        busy_o, chunk_valid_o, chunk_multi_o, done_o;
    logic [63:0] chunk_addr_o;
    logic [15:0] chunk_width_o, chunk_height_o;
    logic [31:0] chunk_pitch_o, chunk_fill_o;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  finished = 1'b0;

    always #5 clk = ~clk;

    fill_split u_fill_split (
        .clk(clk), .rst(rst), .start_i(start_i), .dst_addr_i(dst_addr_i),
        .size_i(size_i), .fill_i(fill_i), .busy_o(busy_o),
        .chunk_valid_o(chunk_valid_o), .chunk_ready_i(chunk_ready_i),
        .chunk_addr_o(chunk_addr_o), .chunk_width_o(chunk_width_o),
        .chunk_height_o(chunk_height_o), .chunk_multi_o(chunk_multi_o),
        .chunk_pitch_o(chunk_pitch_o), .chunk_fill_o(chunk_fill_o), .done_o(done_o)
    );

    task automatic chk(input bit ok, input string tag,
                       input longint unsigned act, input longint unsigned exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic void ref_chunk(input longint unsigned rem,
                                      output longint unsigned w,
                                      output longint unsigned h,
                                      output string tag);
        if (rem >= SQ) begin
            w = 32768; h = 32768; tag = "R2 square";
        end else if (rem >= ROW) begin
            w = 32768; h = rem / ROW; tag = "R3 rows";
        end else begin
            w = rem / 4; h = 1; tag = "R4 short";
        end
    endfunction

    task automatic run_req(input longint unsigned addr, input longint unsigned size,
                           input logic [31:0] fill, input int stall_pct, input bit inject);
        longint unsigned ea = addr;
        longint unsigned rem = size;
        longint unsigned total = 0;
        longint unsigned w, h;
        string tag;
        bit injected = 1'b0;
        bit stalled = 1'b0;
        @(negedge clk);
        start_i = 1'b1; dst_addr_i = addr; size_i = size; fill_i = fill;
        @(negedge clk);
        start_i = 1'b0; fill_i = ~fill; dst_addr_i = ~addr; size_i = 64'd12;
        while (rem >= 4) begin
            ref_chunk(rem, w, h, tag);
            chk(chunk_valid_o == 1'b1, "R5 valid while bytes remain", 64'(chunk_valid_o), 1);
            chk(chunk_addr_o == ea, {tag, " R5 addr"}, chunk_addr_o, ea);
            chk(64'(chunk_width_o) == w, {tag, " width"}, 64'(chunk_width_o), w);
            chk(64'(chunk_height_o) == h, {tag, " height"}, 64'(chunk_height_o), h);
            chk(chunk_multi_o == (h > 1), "R6 multi flag", 64'(chunk_multi_o), 64'(h > 1));
            chk(chunk_pitch_o == 32'd131072, "R7 pitch", 64'(chunk_pitch_o), 131072);
            chk(chunk_fill_o == fill, "R7 fill latched", 64'(chunk_fill_o), 64'(fill));
            if (stalled)
                chk(chunk_addr_o == ea && 64'(chunk_width_o) == w,
                    injected ? "R11 start ignored / R8 hold" : "R8 hold", chunk_addr_o, ea);
            stalled = ($urandom_range(99) < stall_pct) || (inject && !injected);
            if (stalled) begin
                chunk_ready_i = 1'b0;
                if (inject && !injected) begin
                    start_i = 1'b1; dst_addr_i = 64'h1234_0000; size_i = 64'd400; injected = 1'b1;
                end
                @(negedge clk);
                start_i = 1'b0;
            end else begin
                chunk_ready_i = 1'b1;
                @(negedge clk);
                chunk_ready_i = 1'b0;
                ea += w * h * 4; rem -= w * h * 4; total += w * h * 4;
            end
        end
        chk(done_o == 1'b1, size < 4 ? "R10 done after tiny start" : "R9 done after last",
            64'(done_o), 1);
        chk(chunk_valid_o == 1'b0, size < 4 ? "R10 no chunk" : "R9 valid low at done",
            64'(chunk_valid_o), 0);
        chk(total == (size & ~64'd3), "R5 total covered", total, size & ~64'd3);
        @(negedge clk);
        chk(done_o == 1'b0 && busy_o == 1'b0, "R9 done single cycle", 64'({done_o, busy_o}), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_bad++; n_cmp++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'h5EED_F111);
        repeat (3) @(negedge clk);
        chk(chunk_valid_o == 1'b0 && done_o == 1'b0 && busy_o == 1'b0, "R1 reset quiet",
            64'({chunk_valid_o, done_o, busy_o}), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(busy_o == 1'b0, "R1 idle after reset", 64'(busy_o), 0);

        run_req(64'h1000, 0, 32'hAAAA_5555, 0, 1'b0);
        run_req(64'h2000, 3, 32'h1, 0, 1'b0);
        run_req(64'h3000, 4, 32'h2, 0, 1'b0);
        run_req(64'h4000, 7, 32'h3, 20, 1'b0);
        run_req(64'h5000, ROW - 1, 32'h4, 0, 1'b0);
        run_req(64'h6000, ROW, 32'h5, 0, 1'b0);
        run_req(64'h7000, 2 * ROW + 5, 32'h6, 30, 1'b1);
        run_req(64'h8000, SQ, 32'h7, 0, 1'b0);
        run_req(64'h9000, SQ - 4, 32'h8, 0, 1'b0);
        run_req(64'hFFFF_FFFF_0000_0000, SQ + 3 * ROW + 14, 32'hDEAD_BEEF, 40, 1'b1);
        run_req(64'hA000, 2 * SQ + ROW + 4, 32'h9, 0, 1'b0);

        for (int i = 0; i < 60; i++) begin
            longint unsigned sz;
            case ($urandom_range(2))
                0: sz = 64'($urandom_range(40));
                1: sz = 64'($urandom_range(32'd600000));
                default: sz = {30'd0, 2'($urandom_range(2)), $urandom()};
            endcase
            run_req({$urandom(), $urandom()}, sz, $urandom(), 35, (i % 7) == 0);
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule